// File: doc/BRIEF.md
# Handshaked Serial-to-Parallel Receiver

This block pulls a short word off a single serial data wire and delivers it to a processor-side register. The exchange starts when the remote source raises a one-cycle ready request. The block answers with a one-cycle acknowledge. It then raises a shift-clock qualifier toward the source for one system cycle per bit. While the qualifier is high, the source presents one data bit per cycle and the block samples it into an internal shift register.

Once the last bit is in, the block raises a word-valid flag and holds the assembled word. The processor side collects the word with a one-cycle load pulse. The load copies the word into the output register and clears the flag. While a transfer is running, or while an uncollected word is waiting, further ready requests are dropped. This keeps a waiting word from being overwritten.

Top module: `ser2par_hs`

## Requirements
- R1: While rst_ni is low, and after it is released, ack_o, sclk_en_o, word_valid_o and par_o are all 0.
- R2: A ready_i pulse sampled high while the block is idle and no word is waiting gives ack_o high for exactly one cycle, in the cycle after the sampling edge.
- R3: sclk_en_o goes high in the cycle after ack_o and stays high for exactly WORD_W (default 4) consecutive cycles. It is low at every other time.
- R4: sdat_i is sampled at every clock edge at which sclk_en_o is high. Each new bit enters at the MSB and the register shifts toward the LSB. The first bit received therefore ends up in bit 0 and the last bit in bit WORD_W-1.
- R5: word_valid_o rises at the edge that captures the last bit, so it is high in the cycle after the final sclk_en_o cycle. It stays high until a load.
- R6: A load_i pulse sampled while word_valid_o is high gives par_o equal to the assembled word, and word_valid_o low, in the next cycle.
- R7: A load_i pulse sampled while word_valid_o is low leaves par_o and word_valid_o unchanged.
- R8: A ready_i pulse sampled during a transfer, or while word_valid_o is high, is dropped: no ack_o and no sclk_en_o follow from it. This includes a ready_i pulse in the same cycle as a collecting load_i.
- R9: par_o keeps its value from the last load, and only changes when a later load collects a new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | 1 | One-cycle transfer request from the serial source |
| ack_o | output | 1 | One-cycle acknowledge toward the source |
| sclk_en_o | output | 1 | Shift-clock qualifier toward the source, high once per bit |
| sdat_i | input | 1 | Serial data bit from the source |
| load_i | input | 1 | One-cycle processor-side collect pulse |
| word_valid_o | output | 1 | A complete word is waiting for collection |
| par_o | output | WORD_W | Processor-side parallel word |

## Verification
A collecting load and a fresh ready request can arrive in the same cycle. In that case the block must decide from the flag it holds at that edge, not from the flag it is about to clear. The bench provokes this on every third word of a full sweep of all sixteen values, raising ready_i and load_i at the same edge. It judges the result in the following cycles: par_o must carry the word, word_valid_o must be low, and neither ack_o nor sclk_en_o may appear. A ready request is also raised in the middle of every odd word's shifting. There, the collected word must match its bit order with no extra acknowledge.

// File: rtl/ser2par_pkg.sv
package ser2par_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACK   = 2'd1,
    ST_SHIFT = 2'd2
  } hs_state_e;

endpackage

// File: rtl/hs_ctrl.sv
module hs_ctrl
  import ser2par_pkg::*;
#(
  parameter int WORD_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_i,
  input  logic load_i,
  output logic ack_o,
  output logic shift_en_o,
  output logic valid_o,
  output logic xfer_o
);

  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  hs_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             valid_q, valid_d;
  logic             accept, last_bit;

  assign accept   = (state_q == ST_IDLE) && ready_i && !valid_q;
  assign last_bit = (state_q == ST_SHIFT) && (cnt_q == LAST);
  assign xfer_o   = load_i && valid_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    valid_d = valid_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_ACK;
      ST_ACK: begin
        state_d = ST_SHIFT;
        cnt_d   = '0;
      end
      ST_SHIFT: begin
        if (last_bit) begin
          state_d = ST_IDLE;
          valid_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (xfer_o) valid_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      valid_q <= valid_d;
    end
  end

  assign ack_o      = (state_q == ST_ACK);
  assign shift_en_o = (state_q == ST_SHIFT);
  assign valid_o    = valid_q;

  p_ack_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  p_ack_follows_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_o && !shift_en_o && !valid_o && ready_i) |=> ack_o);
  p_shift_after_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> shift_en_o);
  p_shift_ends_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_bit |=> !shift_en_o);
  p_valid_on_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_en_o && !$past(shift_en_o) ? 1'b1 : 1'b1) && $fell(shift_en_o) |-> valid_o);
  p_busy_drops_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((shift_en_o || valid_o) && ready_i) |=> !ack_o);
  p_load_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |=> !valid_o);
  p_idle_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !valid_o && !shift_en_o) |=> !valid_o);

endmodule

// File: rtl/shift_in.sv
module shift_in #(
  parameter int WORD_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sdat_i,
  output logic [WORD_W-1:0] word_o
);

  logic [WORD_W-1:0] sh_q;

  // MSB takes the new bit; every other stage takes its upper neighbour
  for (genvar i = 0; i < WORD_W; i++) begin : g_stage
    logic nxt;
    if (i == WORD_W - 1) begin : g_top
      assign nxt = sdat_i;
    end else begin : g_mid
      assign nxt = sh_q[i+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   sh_q[i] <= 1'b0;
      else if (en_i) sh_q[i] <= nxt;
    end
  end

  assign word_o = sh_q;

  p_hold_when_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(word_o));
  p_msb_takes_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (word_o[WORD_W-1] == $past(sdat_i)));

endmodule

// File: rtl/xfer_reg.sv
module xfer_reg #(
  parameter int WORD_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] par_o
);

  logic [WORD_W-1:0] par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     par_q <= '0;
    else if (xfer_i) par_q <= word_i;
  end

  assign par_o = par_q;

  p_hold_between_loads_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |=> $stable(par_o));
  p_load_copies_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |=> (par_o == $past(word_i)));

endmodule

// File: rtl/ser2par_hs.sv
module ser2par_hs #(
  parameter int WORD_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ready_i,
  output logic              ack_o,
  output logic              sclk_en_o,
  input  logic              sdat_i,
  input  logic              load_i,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] par_o
);

  logic              shift_en, xfer;
  logic [WORD_W-1:0] word;

  hs_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ready_i   (ready_i),
    .load_i    (load_i),
    .ack_o     (ack_o),
    .shift_en_o(shift_en),
    .valid_o   (word_valid_o),
    .xfer_o    (xfer)
  );

  shift_in #(.WORD_W(WORD_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (shift_en),
    .sdat_i(sdat_i),
    .word_o(word)
  );

  xfer_reg #(.WORD_W(WORD_W)) u_xfer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .xfer_i(xfer),
    .word_i(word),
    .par_o (par_o)
  );

  assign sclk_en_o = shift_en;

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!ack_o && !sclk_en_o && !word_valid_o && par_o == '0));
  p_ack_shift_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && sclk_en_o));

endmodule

// File: tb/ser2par_hs_test.sv
`timescale 1ns/1ps
module ser2par_hs_test;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ready = 1'b0;
  logic         sdat = 1'b0;
  logic         load = 1'b0;
  logic         ack, sclk_en, valid;
  logic [W-1:0] par;

  int  vectors = 0;
  int  miscompares = 0;
  bit  done = 1'b0;
  logic [W-1:0] last_par = '0;

  always #5 clk = ~clk;

  ser2par_hs #(.WORD_W(W)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ready_i     (ready),
    .ack_o       (ack),
    .sclk_en_o   (sclk_en),
    .sdat_i      (sdat),
    .load_i      (load),
    .word_valid_o(valid),
    .par_o       (par)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one full handshake and bit stream; inputs change at negedges
  task automatic send(input logic [W-1:0] w, input bit poke);
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    chk("R2 ack after ready", int'(ack), 1);
    chk("R3 no shift during ack", int'(sclk_en), 0);
    @(negedge clk);
    chk("R2 ack single cycle", int'(ack), 0);
    for (int i = 0; i < W; i++) begin
      chk("R3 shift enable high", int'(sclk_en), 1);
      chk("R5 valid low while shifting", int'(valid), 0);
      sdat  = w[i];
      ready = poke && (i == 1);
      @(negedge clk);
      ready = 1'b0;
      chk("R8 no ack while shifting", int'(ack), 0);
    end
    chk("R3 shift enable low after word", int'(sclk_en), 0);
    chk("R5 valid after last bit", int'(valid), 1);
    chk("R9 par held before load", int'(par), int'(last_par));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ack in reset", int'(ack), 0);
    chk("R1 shift in reset", int'(sclk_en), 0);
    chk("R1 valid in reset", int'(valid), 0);
    chk("R1 par in reset", int'(par), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ack after reset", int'(ack), 0);
    chk("R1 par after reset", int'(par), 0);

    // load with nothing waiting
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk("R7 idle load keeps par", int'(par), 0);
    chk("R7 idle load keeps valid", int'(valid), 0);

    for (int w = 0; w < (1 << W); w++) begin
      logic [W-1:0] wv;
      wv = W'(w);
      send(wv, w[0]);
      // ready while a word waits
      ready = 1'b1;
      @(negedge clk);
      ready = 1'b0;
      chk("R8 no ack while word waits", int'(ack), 0);
      @(negedge clk);
      chk("R8 no shift while word waits", int'(sclk_en), 0);
      chk("R9 par unchanged while waiting", int'(par), int'(last_par));
      // collect, sometimes with a coincident ready
      load  = 1'b1;
      ready = (w % 3 == 0);
      @(negedge clk);
      load  = 1'b0;
      ready = 1'b0;
      chk("R6 par takes word", int'(par), w);
      chk("R6 valid cleared", int'(valid), 0);
      chk("R8 no ack on collect cycle", int'(ack), 0);
      last_par = wv;
      @(negedge clk);
      chk("R8 no shift after collect", int'(sclk_en), 0);
      // stray load
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      chk("R7 stray load keeps par", int'(par), w);
      chk("R7 stray load keeps valid", int'(valid), 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule